// File: doc/BRIEF.md
# Quad-Line Serial Flash Command Front End

This block is the device-side command front end of a small serial flash that normally runs every phase of a command (opcode, address, data) on four data lines. It watches the serial clock and chip select, assembles opcodes and a 24-bit address from 4-bit nibbles, and turns the accepted opcodes into three internal operations: a fast array read, a page program and an identification read. A small on-chip byte array stands in for the flash core. Opcodes that have no meaning in the four-line mode are dropped without any effect.

While an external high-voltage program or erase is in progress (signalled by the digital input `vppHigh`), the front end instead takes each new command one bit at a time on DQ0. In that state only status polling is answered, and the status byte is returned on DQ1. Four-line operation returns at the first command that starts after `vppHigh` falls. The block runs on a fast system clock that oversamples the serial clock. Data lines are split into an input bus, an output bus and a per-line output enable, so that a pad ring can build the bidirectional pins.

Top module: `quad_flash_cmd_front`

## Requirements
- R1: In four-line mode, opcodes EBh, 6Bh and 0Bh all start the same fast read. Six address nibbles follow, then 10 dummy clocks. Each array byte is then returned high nibble first, one nibble per clock, with all four enables set (dqOe = 4'hF). The address advances after every byte and wraps from the last array byte to byte 0. Only the low array-index bits of the 24-bit address are used. Every output change follows a falling serial-clock edge.
- R2: Opcodes 02h, 12h and 32h all start the same page program. After the six address nibbles, data bytes arrive high nibble first on DQ3..DQ0. Each completed byte replaces the addressed array byte with old AND new, so a program can only clear bits.
- R3: During a page program the address advances only within its 256-byte page. After the last byte of the page it wraps to the first byte of the same page.
- R4: If chip select rises after only one nibble of a program data byte, that byte is discarded. Bytes completed before it stay written.
- R5: Opcode AFh returns exactly three identification bytes (default 5Ah, C3h, 17h), high nibble first on four lines. The first nibble appears on the falling edge that ends the opcode. After the sixth nibble the lines are released (dqOe = 0) for the rest of the command.
- R6: Any other four-line opcode is ignored until chip select rises: the block drives no line and changes no array byte. This covers 03h, 3Bh, BBh, A2h, D2h, 9Fh, 05h and 00h.
- R7: A command that begins while vppHigh is 1 is received one bit per clock on DQ0, MSB first. Only opcode 05h is answered. It returns the status byte {7'b0, vppHigh} on DQ1 alone (dqOe = 4'b0010), MSB first, repeating every 8 clocks. The busy bit follows vppHigh as it is at each falling edge. Every other opcode, including any sequence of four-line nibbles, is ignored.
- R8: The line mode is chosen while chip select is high. A command already in progress keeps its mode when vppHigh changes. The first command that starts after vppHigh falls runs in four-line mode.
- R9: Chip select high ends any command and returns the decoder to the opcode phase. All output enables are 0 from the clock after chip select rises.
- R10: After reset all output enables are 0 and every array byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial clock |
| rstN | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| dqIn | input | 4 | Sampled data lines DQ3..DQ0 |
| vppHigh | input | 1 | High-voltage operation in progress |
| dqOut | output | 4 | Output values for DQ3..DQ0 |
| dqOe | output | 4 | Per-line output enable, 1 = drive |

## Verification
The bound checker watches four things on every cycle: that the lines are released after chip select rises, that the enable takes only its three legal codes, and that output values and the start of driving only ever follow a falling serial-clock edge. Opcode aliasing, the AND-only program, page and array wrap, partial-byte discard, the three-byte identification and the single-line status polling with its live busy bit all depend on array contents and command sequences. Only the bench scenarios show these: they program and read back the whole array and compare each byte with a model computed arithmetically.

// File: rtl/qfd_pkg.sv
`timescale 1ns/1ps
package qfd_pkg;

  typedef enum logic [1:0] {
    SRC_MEM_HI,
    SRC_MEM_LO,
    SRC_ID,
    SRC_STAT
  } outSrc_e;

  typedef struct packed {
    logic    shiftQuad;
    logic    shiftLine;
    logic    addrShift;
    logic    addrNext;
    logic    progByte;
    logic    outLoad;
    logic    outOff;
    outSrc_e src;
    logic [2:0] sel;
  } dpCtl_t;

endpackage

// File: rtl/qfd_ctrl.sv
`timescale 1ns/1ps
module qfd_ctrl
  import qfd_pkg::*;
#(
  parameter int          ADDR_W        = 24,
  parameter int          DUMMY_CLKS    = 10,
  parameter int          ID_BYTES      = 3,
  parameter logic [7:0]  ID_OPCODE     = 8'hAF,
  parameter logic [7:0]  STATUS_OPCODE = 8'h05
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sckRise,
  input  logic       sckFall,
  input  logic       vppHigh,
  input  logic [7:0] quadByte,
  input  logic [7:0] lineByte,
  output dpCtl_t     ctl
);

  localparam int ADDR_NIBS = ADDR_W / 4;
  localparam int ID_NIBS   = 2 * ID_BYTES;
  localparam int CNT_W     = ($clog2(DUMMY_CLKS + 1) > 4) ? $clog2(DUMMY_CLKS + 1) : 4;
  localparam logic [CNT_W-1:0] LAST_ADDR  = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] LAST_DUMMY = CNT_W'(DUMMY_CLKS - 1);
  localparam logic [CNT_W-1:0] ID_END     = CNT_W'(ID_NIBS);
  localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(7);

  typedef enum logic [3:0] {
    ST_QOPC, ST_QADDR, ST_DUMMY, ST_RDOUT, ST_PROG,
    ST_IDOUT, ST_LOPC, ST_LOUT, ST_IGNORE
  } state_e;

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic             rdOp;
  logic             nibHi;

  function automatic logic isRead(input logic [7:0] op);
    return (op == 8'hEB) || (op == 8'h6B) || (op == 8'h0B);
  endfunction

  function automatic logic isProg(input logic [7:0] op);
    return (op == 8'h02) || (op == 8'h12) || (op == 8'h32);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_QOPC;
      cnt   <= '0;
      rdOp  <= 1'b0;
      nibHi <= 1'b1;
    end else if (csN) begin
      state <= vppHigh ? ST_LOPC : ST_QOPC;
      cnt   <= '0;
      nibHi <= 1'b1;
    end else begin
      unique case (state)
        ST_QOPC: if (sckRise) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(1)) begin
            cnt <= '0;
            if (isRead(quadByte)) begin
              state <= ST_QADDR;
              rdOp  <= 1'b1;
            end else if (isProg(quadByte)) begin
              state <= ST_QADDR;
              rdOp  <= 1'b0;
            end else if (quadByte == ID_OPCODE) begin
              state <= ST_IDOUT;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_QADDR: if (sckRise) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_ADDR) begin
            cnt   <= '0;
            nibHi <= 1'b1;
            state <= rdOp ? ST_DUMMY : ST_PROG;
          end
        end
        ST_DUMMY: if (sckRise) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_DUMMY) begin
            cnt   <= '0;
            state <= ST_RDOUT;
          end
        end
        ST_RDOUT: if (sckFall) nibHi <= !nibHi;
        ST_PROG:  if (sckRise) nibHi <= !nibHi;
        ST_IDOUT: if (sckFall) begin
          if (cnt == ID_END) state <= ST_IGNORE;
          else               cnt   <= cnt + 1'b1;
        end
        ST_LOPC: if (sckRise) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_BIT) begin
            cnt   <= '0;
            state <= (lineByte == STATUS_OPCODE) ? ST_LOUT : ST_IGNORE;
          end
        end
        ST_LOUT: if (sckFall) cnt <= (cnt == LAST_BIT) ? '0 : cnt + 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl     = '0;
    ctl.src = SRC_MEM_HI;
    if (csN) begin
      ctl.outOff = 1'b1;
    end else begin
      unique case (state)
        ST_QOPC:  ctl.shiftQuad = sckRise;
        ST_QADDR: ctl.addrShift = sckRise;
        ST_PROG: begin
          ctl.shiftQuad = sckRise;
          ctl.progByte  = sckRise && !nibHi;
        end
        ST_RDOUT: begin
          ctl.outLoad  = sckFall;
          ctl.src      = nibHi ? SRC_MEM_HI : SRC_MEM_LO;
          ctl.addrNext = sckFall && !nibHi;
        end
        ST_IDOUT: begin
          ctl.src = SRC_ID;
          ctl.sel = cnt[2:0];
          if (cnt == ID_END) ctl.outOff  = sckFall;
          else               ctl.outLoad = sckFall;
        end
        ST_LOPC: ctl.shiftLine = sckRise;
        ST_LOUT: begin
          ctl.outLoad = sckFall;
          ctl.src     = SRC_STAT;
          ctl.sel     = ~cnt[2:0];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/qfd_datapath.sv
`timescale 1ns/1ps
module qfd_datapath
  import qfd_pkg::*;
#(
  parameter int   ARRAY_AW = 9,
  parameter int   PAGE_AW  = 8,
  parameter int   ID_BYTES = 3,
  parameter logic [8*ID_BYTES-1:0] ID_VALUE = 24'h5AC317
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sck,
  input  logic [3:0] dqIn,
  input  logic       vppHigh,
  input  dpCtl_t     ctl,
  output logic       sckRise,
  output logic       sckFall,
  output logic [7:0] quadByte,
  output logic [7:0] lineByte,
  output logic [3:0] dqOut,
  output logic [3:0] dqOe
);

  localparam int ARRAY_BYTES = 1 << ARRAY_AW;
  localparam int ID_NIBS     = 2 * ID_BYTES;

  logic             sckQ;
  logic [7:0]       shiftReg;
  logic [ARRAY_AW-1:0] addrReg;
  logic [7:0]       mem [ARRAY_BYTES];
  logic [3:0]       idNibs [8];
  logic [7:0]       statusByte;
  logic [7:0]       curByte;

  assign sckRise    = sck && !sckQ;
  assign sckFall    = !sck && sckQ;
  assign quadByte   = {shiftReg[3:0], dqIn};
  assign lineByte   = {shiftReg[6:0], dqIn[0]};
  assign statusByte = {7'b0, vppHigh};
  assign curByte    = mem[addrReg];

  for (genvar i = 0; i < 8; i++) begin : g_idNib
    if (i < ID_NIBS) begin : g_used
      assign idNibs[i] = ID_VALUE[8*ID_BYTES-1-4*i -: 4];
    end else begin : g_pad
      assign idNibs[i] = 4'h0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckQ     <= 1'b0;
      shiftReg <= '0;
      addrReg  <= '0;
    end else begin
      sckQ <= sck;
      if (ctl.shiftQuad) shiftReg <= quadByte;
      if (ctl.shiftLine) shiftReg <= lineByte;
      if (ctl.addrShift) addrReg  <= {addrReg[ARRAY_AW-5:0], dqIn};
      if (ctl.addrNext)  addrReg  <= addrReg + 1'b1;
      if (ctl.progByte)  addrReg[PAGE_AW-1:0] <= addrReg[PAGE_AW-1:0] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ARRAY_BYTES; i++) mem[i] <= 8'hFF;
    end else if (ctl.progByte) begin
      mem[addrReg] <= curByte & quadByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dqOut <= 4'h0;
      dqOe  <= 4'h0;
    end else if (ctl.outOff) begin
      dqOe <= 4'h0;
    end else if (ctl.outLoad) begin
      unique case (ctl.src)
        SRC_MEM_HI: begin dqOut <= curByte[7:4];        dqOe <= 4'hF; end
        SRC_MEM_LO: begin dqOut <= curByte[3:0];        dqOe <= 4'hF; end
        SRC_ID:     begin dqOut <= idNibs[ctl.sel];     dqOe <= 4'hF; end
        SRC_STAT:   begin
          dqOut <= {2'b00, statusByte[ctl.sel], 1'b0};
          dqOe  <= 4'b0010;
        end
      endcase
    end
  end

endmodule

// File: rtl/quad_flash_cmd_front.sv
`timescale 1ns/1ps
module quad_flash_cmd_front
  import qfd_pkg::*;
#(
  parameter int          ARRAY_AW      = 9,
  parameter int          PAGE_AW       = 8,
  parameter int          ADDR_W        = 24,
  parameter int          DUMMY_CLKS    = 10,
  parameter int          ID_BYTES      = 3,
  parameter logic [7:0]  ID_OPCODE     = 8'hAF,
  parameter logic [7:0]  STATUS_OPCODE = 8'h05,
  parameter logic [8*ID_BYTES-1:0] ID_VALUE = 24'h5AC317
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sck,
  input  logic       csN,
  input  logic [3:0] dqIn,
  input  logic       vppHigh,
  output logic [3:0] dqOut,
  output logic [3:0] dqOe
);

  dpCtl_t     ctl;
  logic       sckRise;
  logic       sckFall;
  logic [7:0] quadByte;
  logic [7:0] lineByte;

  qfd_ctrl #(
    .ADDR_W(ADDR_W), .DUMMY_CLKS(DUMMY_CLKS), .ID_BYTES(ID_BYTES),
    .ID_OPCODE(ID_OPCODE), .STATUS_OPCODE(STATUS_OPCODE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sckRise(sckRise), .sckFall(sckFall),
    .vppHigh(vppHigh), .quadByte(quadByte), .lineByte(lineByte), .ctl(ctl)
  );

  qfd_datapath #(
    .ARRAY_AW(ARRAY_AW), .PAGE_AW(PAGE_AW), .ID_BYTES(ID_BYTES), .ID_VALUE(ID_VALUE)
  ) i_dp (
    .clk(clk), .rstN(rstN), .sck(sck), .dqIn(dqIn), .vppHigh(vppHigh), .ctl(ctl),
    .sckRise(sckRise), .sckFall(sckFall), .quadByte(quadByte), .lineByte(lineByte),
    .dqOut(dqOut), .dqOe(dqOe)
  );

endmodule

// File: rtl/qfd_checker.sv
`timescale 1ns/1ps
module qfd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       sck,
  input logic [3:0] dqOut,
  input logic [3:0] dqOe
);

  AST_RELEASE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (dqOe == 4'h0)); // R9

  AST_LEGAL_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (dqOe == 4'h0) || (dqOe == 4'hF) || (dqOe == 4'b0010)); // R7

  AST_OUT_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dqOut) |-> ($past(sck, 2) && !$past(sck))); // R1

  AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dqOe != 4'h0) |-> ($past(sck, 2) && !$past(sck) && !$past(csN))); // R5

endmodule

bind quad_flash_cmd_front qfd_checker i_qfd_checker (
  .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .dqOut(dqOut), .dqOe(dqOe)
);

// File: tb/test_quad_flash_cmd_front.sv
`timescale 1ns/1ps
module test_quad_flash_cmd_front;

  localparam int NBYTES = 512;

  logic       clk = 1'b0;
  logic       rstN;
  logic       sck;
  logic       csN;
  logic [3:0] dqIn;
  logic       vppHigh;
  logic [3:0] dqOut;
  logic [3:0] dqOe;

  int total = 0;
  int bad   = 0;
  logic [7:0] model [NBYTES];

  always #2.5 clk = ~clk;

  quad_flash_cmd_front i_quad_flash_cmd_front (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .dqIn(dqIn),
    .vppHigh(vppHigh), .dqOut(dqOut), .dqOe(dqOe)
  );

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic qclk(input logic [3:0] d);
    @(negedge clk); dqIn = d; sck = 1'b1;
    @(negedge clk); @(negedge clk); sck = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic lclk(input logic b);
    qclk({3'b101, b});
  endtask

  task automatic qbyte(input logic [7:0] b);
    qclk(b[7:4]); qclk(b[3:0]);
  endtask

  task automatic lbyte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) lclk(b[i]);
  endtask

  task automatic qaddr(input logic [23:0] a);
    qbyte(a[23:16]); qbyte(a[15:8]); qbyte(a[7:0]);
  endtask

  task automatic csLow();
    @(negedge clk); csN = 1'b0;
  endtask

  task automatic csHigh();
    @(negedge clk); csN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic readCmd(input logic [7:0] op, input logic [23:0] a, input int n, input string req);
    csLow(); qbyte(op); qaddr(a);
    for (int i = 0; i < 10; i++) qclk(4'h0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] got;
      logic [7:0] exp;
      logic       oeOk;
      exp = model[(int'(a[8:0]) + i) % NBYTES];
      got[7:4] = dqOut; oeOk = (dqOe == 4'hF);
      qclk(4'h0);
      got[3:0] = dqOut; oeOk = oeOk && (dqOe == 4'hF);
      qclk(4'h0);
      chk(oeOk && got == exp, req, {dqOe, got}, {4'hF, exp});
    end
    csHigh();
  endtask

  task automatic progCmd(input logic [7:0] op, input logic [23:0] a, input int n, input int seed);
    csLow(); qbyte(op); qaddr(a);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      logic [8:0] idx;
      d   = 8'((i * 37 + seed) ^ (i >> 3));
      idx = {a[8], 8'(a[7:0] + 8'(i))};
      model[idx] = model[idx] & d;
      qbyte(d);
    end
    csHigh();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [23:0] idVal;
    logic [7:0]  ops [8];
    idVal = 24'h5AC317;
    for (int i = 0; i < NBYTES; i++) model[i] = 8'hFF;
    rstN = 1'b0; csN = 1'b1; sck = 1'b0; dqIn = 4'h0; vppHigh = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R10: reset state
    chk(dqOe == 4'h0, "R10 enable after reset", dqOe, 0);
    readCmd(8'hEB, 24'h000000, 16, "R10 erased array");

    // R2: two program aliases fill both pages, R1: full read with array wrap
    progCmd(8'h02, 24'h000000, 256, 11);
    progCmd(8'h12, 24'h000100, 256, 90);
    readCmd(8'hEB, 24'h000000, NBYTES + 2, "R1 R2 full array read");

    // R3: third alias, page wrap inside page 1
    progCmd(8'h32, 24'h0001F0, 32, 200);
    readCmd(8'h6B, 24'h0001E0, 32, "R3 page tail");
    readCmd(8'h0B, 24'h000100, 32, "R3 page head wrap");

    // R4: chip select raised after one nibble of the third byte
    csLow(); qbyte(8'h02); qaddr(24'h000005);
    model[5] = model[5] & 8'h00; qbyte(8'h00);
    model[6] = model[6] & 8'h00; qbyte(8'h00);
    qclk(4'h0);
    csHigh();
    readCmd(8'h0B, 24'h000004, 4, "R4 partial byte discarded");

    // R1: upper address bits ignored, array wrap
    readCmd(8'h6B, 24'hABC1FE, 4, "R1 high address bits");

    // R5: identification read
    csLow(); qbyte(8'hAF);
    for (int i = 0; i < 6; i++) begin
      logic [3:0] e;
      e = idVal[23 - 4*i -: 4];
      chk(dqOe == 4'hF && dqOut == e, "R5 id nibble", {dqOe, dqOut}, {4'hF, e});
      qclk(4'h0);
    end
    for (int i = 0; i < 3; i++) begin
      chk(dqOe == 4'h0, "R5 release after id", dqOe, 0);
      qclk(4'h0);
    end
    csHigh();

    // R6: unsupported opcodes change nothing and drive nothing
    ops = '{8'h03, 8'h3B, 8'hBB, 8'hA2, 8'hD2, 8'h9F, 8'h05, 8'h00};
    for (int k = 0; k < 8; k++) begin
      logic seenOe;
      seenOe = 1'b0;
      csLow(); qbyte(ops[k]); qaddr(24'h000040);
      for (int i = 0; i < 12; i++) begin
        qclk(4'h0);
        if (dqOe != 4'h0) seenOe = 1'b1;
      end
      csHigh();
      chk(!seenOe, "R6 no drive on rejected opcode", ops[k], 0);
    end
    readCmd(8'hEB, 24'h000040, 2, "R6 array untouched");

    // R7: single-line status polling while vppHigh
    vppHigh = 1'b1;
    csHigh();
    csLow(); lbyte(8'h05);
    for (int k = 0; k < 24; k++) begin
      logic eb;
      eb = (k % 8 == 7);
      chk(dqOe == 4'b0010 && dqOut[1] == eb, "R7 status bit", {dqOe, dqOut}, {4'b0010, 2'b00, eb, 1'b0});
      lclk(1'b0);
    end
    // R8: mode of a running command is kept; busy bit follows vppHigh
    @(negedge clk); vppHigh = 1'b0;
    lclk(1'b0);
    for (int k = 0; k < 8; k++) begin
      chk(dqOe == 4'b0010 && dqOut[1] == 1'b0, "R8 status after drop", {dqOe, dqOut}, {4'b0010, 4'b0000});
      lclk(1'b0);
    end
    csHigh();

    // R7: other commands under vppHigh ignored
    vppHigh = 1'b1;
    csHigh();
    begin
      logic seenOe;
      seenOe = 1'b0;
      csLow(); qbyte(8'hEB); qaddr(24'h000000);
      for (int i = 0; i < 12; i++) begin qclk(4'h0); if (dqOe != 4'h0) seenOe = 1'b1; end
      csHigh();
      chk(!seenOe, "R7 quad read ignored in line mode", 1, 0);
      seenOe = 1'b0;
      csLow(); lbyte(8'h02); lbyte(8'h00); lbyte(8'h00); lbyte(8'h00); lbyte(8'h00);
      for (int i = 0; i < 8; i++) begin lclk(1'b0); if (dqOe != 4'h0) seenOe = 1'b1; end
      csHigh();
      chk(!seenOe, "R7 line program ignored", 1, 0);
    end

    // R8: quad mode resumes after vppHigh falls
    vppHigh = 1'b0;
    csHigh();
    readCmd(8'hEB, 24'h000000, 4, "R8 quad resumes");

    // R9: chip select mid-read releases lines and restarts decode
    csLow(); qbyte(8'hEB); qaddr(24'h000010);
    for (int i = 0; i < 10; i++) qclk(4'h0);
    chk(dqOe == 4'hF, "R9 driving before deselect", dqOe, 4'hF);
    qclk(4'h0);
    @(negedge clk); csN = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(dqOe == 4'h0, "R9 release on deselect", dqOe, 0);
    @(negedge clk);
    csLow(); qbyte(8'hAF);
    chk(dqOe == 4'hF && dqOut == 4'h5, "R9 opcode phase after deselect", {dqOe, dqOut}, 8'hF5);
    csHigh();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule